// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Unit

This block is a chain of interrupt-identification links that sits between several requesting devices and one processor. Every link keeps a pending flag for its own device. All pending flags are ORed onto one shared interrupt line. When the processor answers with an acknowledge, the acknowledge enters the link nearest the processor and ripples down the chain. A link with nothing pending lets it through. The first link with a pending request stops it and places its fixed identifier on a shared data bus. Priority therefore comes only from position in the chain.

The set of links that take part in an acknowledge is frozen when the acknowledge is first seen. It stays fixed until the acknowledge is removed, so the winner cannot change while the processor reads the bus. When the processor drops the acknowledge, the winning link clears its pending flag. The shared line then falls unless another link is still waiting. An acknowledge that no link claims leaves the bus at zero, which the processor treats as a spurious interrupt.

The identifier of link k is ID_BASE + k and is never zero. Link 0 is nearest the processor. The bus is the OR of the link outputs, and every link that does not hold the acknowledge drives zero.

Top module: `intack_chain`

## Requirements
- R1: `irq_o` is high in the cycle after any `req_i` bit is sampled high. It stays high while any link is pending and is low when no link is pending.
- R2: After reset, `irq_o`, `bus_o`, `grant_o` and `ack_tail_o` are all zero.
- R3: One cycle after `ack_i` is first sampled high, `grant_o` has a single bit set at the lowest-index pending link k, and `bus_o` equals ID_BASE + k.
- R4: A link that is not pending passes the acknowledge on. `ack_tail_o` is high only while an acknowledge is active and no link has claimed it, and links after the winner never receive a grant.
- R5: `bus_o` is zero whenever no link holds a grant. An acknowledge with no pending link leaves `bus_o` at zero and drives `ack_tail_o` high.
- R6: In the cycle after `ack_i` is sampled low again, `grant_o` and `bus_o` are zero. The winner's pending flag is cleared and every other pending flag is kept.
- R7: A request that arrives while the acknowledge is held does not change the winner or the bus value. It stays pending and is served by a later acknowledge.
- R8: A request sampled in the same cycle that `ack_i` is first sampled high takes part in that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_LINKS | Request from each device; bit 0 belongs to the link nearest the processor |
| ack_i | input | 1 | Acknowledge from the processor |
| irq_o | output | 1 | Shared interrupt line, the OR of all pending flags |
| bus_o | output | ID_W | Identifier data bus, the OR of all link outputs |
| ack_tail_o | output | 1 | Acknowledge leaving the last link |
| grant_o | output | N_LINKS | Link that currently holds the acknowledge |

## Verification
The checker tests several rules on every cycle. At most one link holds the grant. The bus is zero without a grant and nonzero with one. The tail acknowledge and a grant are never active together. A grant appears only after an acknowledge, the grant stays fixed while the acknowledge is held, it is gone one cycle after the acknowledge falls, and the shared line rises only after a request. The directed scenarios show what the cycle rules cannot: which link wins for each mix of requests, the exact identifier value, that a served link is cleared while the others keep their requests, that a request made during an acknowledge waits for a later one, and that a request arriving in the same cycle as the acknowledge is included.

// File: rtl/intack_pkg.sv
package intack_pkg;

    // State of one chain link
    typedef struct packed {
        logic pend;   // device request latched, not yet served
        logic snap;   // pending value frozen at acknowledge start
    } link_st_t;

    // State of the acknowledge phase tracker
    typedef struct packed {
        logic ack;    // registered acknowledge
    } phase_st_t;

endpackage

// File: rtl/intack_phase.sv
module intack_phase
    import intack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic active_o,
    output logic rise_o,
    output logic fall_o
);

    phase_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = ack_i;
        active_o = st_q.ack;
        rise_o   = ack_i & ~st_q.ack;
        fall_o   = ~ack_i & st_q.ack;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/intack_link.sv
module intack_link
    import intack_pkg::*;
#(
    parameter int unsigned          ID_W    = 8,
    parameter logic [ID_W-1:0]      LINK_ID = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            rise_i,
    input  logic            fall_i,
    input  logic            ack_in_i,
    output logic            ack_out_o,
    output logic            claim_o,
    output logic            pend_o,
    output logic [ID_W-1:0] id_o
);

    link_st_t st_d, st_q;
    logic     claim;

    always_comb begin
        st_d  = st_q;
        claim = ack_in_i & st_q.snap;

        // Latch the device request
        st_d.pend = st_q.pend | req_i;
        // Identifier read: the acknowledge falls while this link holds it
        if (fall_i && claim) begin
            st_d.pend = 1'b0;
        end

        // Freeze participation for the whole acknowledge
        if (rise_i) begin
            st_d.snap = st_q.pend | req_i;
        end else if (fall_i) begin
            st_d.snap = 1'b0;
        end

        ack_out_o = ack_in_i & ~st_q.snap;
        claim_o   = claim;
        pend_o    = st_q.pend;
        id_o      = claim ? LINK_ID : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/intack_bus_or.sv
module intack_bus_or #(
    parameter int unsigned N_SRC = 4,
    parameter int unsigned W     = 8
) (
    input  logic [N_SRC-1:0][W-1:0] src_i,
    output logic [W-1:0]            bus_o
);

    always_comb begin
        bus_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            bus_o = bus_o | src_i[i];
        end
    end

endmodule

// File: rtl/intack_chain.sv
module intack_chain #(
    parameter int unsigned N_LINKS = 4,
    parameter int unsigned ID_W    = 8,
    parameter int unsigned ID_BASE = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINKS-1:0] req_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    bus_o,
    output logic               ack_tail_o,
    output logic [N_LINKS-1:0] grant_o
);

    logic                          ack_active;
    logic                          ack_rise;
    logic                          ack_fall;
    logic [N_LINKS:0]              ack_chain;
    logic [N_LINKS-1:0]            pend;
    logic [N_LINKS-1:0][ID_W-1:0]  ids;

    intack_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_i    (ack_i),
        .active_o (ack_active),
        .rise_o   (ack_rise),
        .fall_o   (ack_fall)
    );

    assign ack_chain[0] = ack_active;

    for (genvar k = 0; k < N_LINKS; k++) begin : g_link
        localparam logic [ID_W-1:0] LID = ID_W'(ID_BASE + k);
        intack_link #(
            .ID_W    (ID_W),
            .LINK_ID (LID)
        ) u_link (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (req_i[k]),
            .rise_i    (ack_rise),
            .fall_i    (ack_fall),
            .ack_in_i  (ack_chain[k]),
            .ack_out_o (ack_chain[k+1]),
            .claim_o   (grant_o[k]),
            .pend_o    (pend[k]),
            .id_o      (ids[k])
        );
    end

    intack_bus_or #(
        .N_SRC (N_LINKS),
        .W     (ID_W)
    ) u_bus (
        .src_i (ids),
        .bus_o (bus_o)
    );

    assign irq_o      = |pend;
    assign ack_tail_o = ack_chain[N_LINKS];

endmodule

// File: rtl/intack_chain_chk.sv
module intack_chain_chk #(
    parameter int unsigned N_LINKS = 4,
    parameter int unsigned ID_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINKS-1:0] req_i,
    input logic               ack_i,
    input logic               irq_o,
    input logic [ID_W-1:0]    bus_o,
    input logic               ack_tail_o,
    input logic [N_LINKS-1:0] grant_o
);

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R5
    bus_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == '0) |-> (bus_o == '0));

    // R3
    bus_claim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> (bus_o != '0));

    // R4
    tail_excl_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_tail_o |-> (grant_o == '0));

    // R3
    grant_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> $past(ack_i));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && $past(ack_i) && $past(ack_i, 2)) |-> $stable(grant_o));

    // R6
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_i) |=> (grant_o == '0));

    // R1
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(req_i != '0));

endmodule

bind intack_chain intack_chain_chk #(
    .N_LINKS (N_LINKS),
    .ID_W    (ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .ack_i      (ack_i),
    .irq_o      (irq_o),
    .bus_o      (bus_o),
    .ack_tail_o (ack_tail_o),
    .grant_o    (grant_o)
);

// File: tb/test_intack_chain.sv
module test_intack_chain;

    localparam int unsigned N       = 4;
    localparam int unsigned W       = 8;
    localparam int unsigned BASE    = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         ack_i = 1'b0;
    logic         irq_o;
    logic [W-1:0] bus_o;
    logic         ack_tail_o;
    logic [N-1:0] grant_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    intack_chain #(.N_LINKS(N), .ID_W(W), .ID_BASE(BASE)) i_intack_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .ack_i      (ack_i),
        .irq_o      (irq_o),
        .bus_o      (bus_o),
        .ack_tail_o (ack_tail_o),
        .grant_o    (grant_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [N-1:0] mask);
        @(negedge clk) req_i = mask;
        @(negedge clk) req_i = '0;
    endtask

    // Raise ack, check winner, drop ack, check release
    task automatic serve(input int win, input string tag);
        @(negedge clk) ack_i = 1'b1;
        @(negedge clk);
        if (win < 0) begin
            check(bus_o == '0, {tag, " R5 bus"}, bus_o, 0);
            check(ack_tail_o == 1'b1, {tag, " R5 tail"}, ack_tail_o, 1);
            check(grant_o == '0, {tag, " R4 grant"}, grant_o, 0);
        end else begin
            check(bus_o == W'(BASE + win), {tag, " R3 bus"}, bus_o, BASE + win);
            check(grant_o == N'(1 << win), {tag, " R3 grant"}, grant_o, 1 << win);
            check(ack_tail_o == 1'b0, {tag, " R4 tail"}, ack_tail_o, 0);
        end
        ack_i = 1'b0;
        @(negedge clk);
        check(bus_o == '0 && grant_o == '0, {tag, " R6 release"}, bus_o, 0);
    endtask

    task automatic t_reset();
        check(irq_o == 1'b0, "R2 irq", irq_o, 0);
        check(bus_o == '0, "R2 bus", bus_o, 0);
        check(grant_o == '0, "R2 grant", grant_o, 0);
        check(ack_tail_o == 1'b0, "R2 tail", ack_tail_o, 0);
    endtask

    task automatic t_single();
        pulse_req(4'b0100);
        check(irq_o == 1'b1, "R1 irq set", irq_o, 1);
        serve(2, "single");
        check(irq_o == 1'b0, "R1 irq clear", irq_o, 0);
    endtask

    task automatic t_priority();
        pulse_req(4'b1010);
        serve(1, "prio first");
        check(irq_o == 1'b1, "R6 other kept", irq_o, 1);
        serve(3, "prio second");
        check(irq_o == 1'b0, "R1 drained", irq_o, 0);
    endtask

    task automatic t_spurious();
        serve(-1, "spurious");
        check(irq_o == 1'b0, "R5 irq idle", irq_o, 0);
    endtask

    task automatic t_midack();
        pulse_req(4'b0100);
        @(negedge clk) ack_i = 1'b1;
        @(negedge clk);
        check(bus_o == W'(BASE + 2), "R3 midack start", bus_o, BASE + 2);
        req_i = 4'b0001;
        @(negedge clk) req_i = '0;
        @(negedge clk);
        check(bus_o == W'(BASE + 2), "R7 bus held", bus_o, BASE + 2);
        check(grant_o == 4'b0100, "R7 grant held", grant_o, 4);
        ack_i = 1'b0;
        @(negedge clk);
        check(irq_o == 1'b1, "R7 late request kept", irq_o, 1);
        serve(0, "R7 late served");
        check(irq_o == 1'b0, "R7 drained", irq_o, 0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk) begin
            req_i = 4'b1000;
            ack_i = 1'b1;
        end
        @(negedge clk) req_i = '0;
        check(bus_o == W'(BASE + 3), "R8 bus", bus_o, BASE + 3);
        check(grant_o == 4'b1000, "R8 grant", grant_o, 8);
        ack_i = 1'b0;
        @(negedge clk);
        check(irq_o == 1'b0, "R8 cleared", irq_o, 0);
    endtask

    task automatic t_full();
        pulse_req(4'b1111);
        for (int k = 0; k < N; k++) begin
            serve(k, "full R3");
        end
        check(irq_o == 1'b0, "R1 full drained", irq_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_spurious();
        t_midack();
        t_same_cycle();
        t_full();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule